// File: doc/BRIEF.md
# DDR Refresh and Self-Refresh Manager

This block lives inside a DDR SDRAM controller and owns every refresh-related command. An interval timer marks each refresh period. Every mark adds one refresh to a saturating debt counter that can hold up to eight. While any debt is outstanding the block raises a request to the controller's command arbiter. The arbiter may postpone the grant, which lets refreshes be deferred and then issued back to back. When the debt hits its ceiling the block also raises an urgent flag, which the arbiter must honour before any other command.

A power-down request is accepted only when all banks are idle and the debt is below the ceiling. The block then sends self-refresh entry: the refresh command encoding with CKE driven low. After that it stays silent until woken. On wake-up it raises CKE, which assumes the clock is already stable. It then holds off all commands for a fixed NOP window and asks for one catch-up refresh before normal operation resumes. A recovery counter started at the CKE rise keeps `read_allowed` low until the DLL relock time has passed.

Top module: `ddr_refresh_mgr`

## Requirements
- R1: In normal operation the interval timer adds one owed refresh every REFI_CYC clock cycles, counted from reset or from the return to normal operation. `arb_req` is high whenever the owed count is non-zero.
- R2: The owed count saturates at MAX_OWED (default 8). `urgent` is high exactly while the count equals MAX_OWED; with no grants it first rises MAX_OWED×REFI_CYC cycles after reset.
- R3: A grant while a refresh is owed makes the command outputs {cs_n, ras_n, cas_n, we_n} read 4'b0001 for one cycle, starting the cycle after the grant, with `cke` high. The owed count drops by one. A timer tick in the same cycle leaves the count unchanged. When no command is being issued the outputs read 4'b1111 (deselect).
- R4: A power-down request is taken only when `banks_idle` is high and `urgent` is low. Otherwise a grant issues an ordinary refresh, or nothing at all.
- R5: When entry is granted, the cycle after the grant shows command 4'b0001 with `cke` low. From then on `cke` stays low, the outputs read deselect, `arb_req` is low, and the owed count and interval timer are cleared.
- R6: `wake_req` during self-refresh raises `cke` in the following cycle.
- R7: For XSNR_CYC cycles starting with the first cycle of high `cke`, only deselect is driven and `arb_req` stays low.
- R8: After that window `arb_req` rises for a catch-up refresh. Its grant issues command 4'b0001 with `cke` high and restores normal operation.
- R9: `read_allowed` is high in normal operation, including straight after reset. After a wake-up it stays low for RECOVER_CYC cycles counted from the first high-`cke` cycle, or until the catch-up refresh has been issued if that comes later.
- R10: A grant received while `arb_req` is low has no effect: the command outputs stay at deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks precharged and idle |
| sleep_req | input | 1 | Power-down (self-refresh) request |
| wake_req | input | 1 | Leave self-refresh; clock is already stable |
| arb_gnt | input | 1 | Command slot grant from the arbiter |
| arb_req | output | 1 | Command slot request to the arbiter |
| urgent | output | 1 | Owed refreshes at the ceiling; must be granted first |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| read_allowed | output | 1 | Reads may be issued by the controller |

## Verification
The hardest state to reach from the ports is the full debt ceiling. Once the ceiling is reached, a power-down request must be refused, and a tick and a refresh landing in the same cycle must cancel out. The bench reaches it by withholding grants for eight full intervals, then asking for power-down with idle banks while granting. Grant-spacing sweeps then drive the counter through every cadence of ticks against grants. The exit sequence is swept by varying how late entry and the catch-up refresh are granted, so that the reopening of reads is set by the recovery count in some cases and by the late catch-up in others.

// File: rtl/refmgr_pkg.sv
package refmgr_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,  // normal operation, timed refreshes
    ST_SLEEP   = 2'd1,  // self-refresh, CKE low
    ST_WAKE    = 2'd2,  // CKE high, NOP hold window
    ST_CATCHUP = 2'd3   // waiting for the extra refresh slot
  } mgr_state_t;

  // Command bundle ordered {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] ddr_cmd_t;

  localparam ddr_cmd_t CMD_DESEL   = 4'b1111;
  localparam ddr_cmd_t CMD_REFRESH = 4'b0001;

  // Next owed count: one up per tick, one down per issued refresh,
  // clamped to the range 0..cap.
  function automatic int unsigned owed_step(int unsigned cur, logic up,
                                            logic down, int unsigned cap);
    int unsigned nxt;
    nxt = cur;
    if (up && !down) begin
      nxt = (cur >= cap) ? cap : cur + 1;
    end else if (down && !up) begin
      nxt = (cur == 0) ? 0 : cur - 1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/refmgr_interval_timer.sv
module refmgr_interval_timer #(
  parameter int unsigned PERIOD_CYC = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic [TW-1:0] cnt_q;

  assign tick = run && (cnt_q == TW'(PERIOD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refmgr_owed_counter.sv
module refmgr_owed_counter
  import refmgr_pkg::*;
#(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          consume,
  input  logic          flush,
  output logic [OW-1:0] owed,
  output logic          urgent
);
  assign urgent = (owed == OW'(MAX_OWED));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else if (flush) begin
      owed <= '0;
    end else begin
      owed <= OW'(owed_step(int'(owed), tick, consume, MAX_OWED));
    end
  end
endmodule

// File: rtl/refmgr_sleep_seq.sv
module refmgr_sleep_seq
  import refmgr_pkg::*;
#(
  parameter int unsigned XSNR_CYC    = 20,
  parameter int unsigned RECOVER_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_fire,
  input  logic       wake_req,
  input  logic       catchup_fire,
  output mgr_state_t state,
  output logic       xsnr_done,
  output logic       recovered
);
  localparam int unsigned XW = $clog2(XSNR_CYC + 1);
  localparam int unsigned RW = $clog2(RECOVER_CYC + 1);

  mgr_state_t    state_q;
  logic [XW-1:0] xs_q;
  logic [RW-1:0] rec_q;

  assign state     = state_q;
  assign xsnr_done = (state_q == ST_WAKE) && (xs_q == XW'(XSNR_CYC - 1));
  assign recovered = (rec_q == RW'(RECOVER_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      xs_q    <= '0;
      rec_q   <= RW'(RECOVER_CYC);
    end else begin
      if (state_q != ST_SLEEP && !recovered) begin
        rec_q <= rec_q + 1'b1;
      end
      case (state_q)
        ST_RUN: begin
          if (enter_fire) state_q <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wake_req) begin
            state_q <= ST_WAKE;
            xs_q    <= '0;
            rec_q   <= '0;
          end
        end
        ST_WAKE: begin
          if (xsnr_done) state_q <= ST_CATCHUP;
          else           xs_q    <= xs_q + 1'b1;
        end
        ST_CATCHUP: begin
          if (catchup_fire) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ddr_refresh_mgr.sv
module ddr_refresh_mgr
  import refmgr_pkg::*;
#(
  parameter int unsigned REFI_CYC    = 780,
  parameter int unsigned XSNR_CYC    = 20,
  parameter int unsigned RECOVER_CYC = 200,
  parameter int unsigned MAX_OWED    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic arb_gnt,
  output logic arb_req,
  output logic urgent,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic read_allowed
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);

  // Named internal events, visible to the bound checker
  mgr_state_t    state_w;
  logic [OW-1:0] owed_w;
  logic          tick_w;
  logic          run_w;
  logic          sleep_ok_w;
  logic          fire_w;
  logic          fire_enter_w;
  logic          fire_ref_w;
  logic          consume_w;
  logic          catchup_fire_w;
  logic          xsnr_done_w;
  logic          recovered_w;
  logic          urgent_w;
  ddr_cmd_t      cmd_q;

  assign run_w          = (state_w == ST_RUN);
  assign sleep_ok_w     = run_w && sleep_req && banks_idle && !urgent_w;
  assign arb_req        = (run_w && ((owed_w != '0) || sleep_ok_w)) ||
                          (state_w == ST_CATCHUP);
  assign fire_w         = arb_req && arb_gnt;
  assign fire_enter_w   = fire_w && sleep_ok_w;
  assign fire_ref_w     = fire_w && !sleep_ok_w;
  assign consume_w      = fire_ref_w && run_w;
  assign catchup_fire_w = fire_w && (state_w == ST_CATCHUP);

  refmgr_interval_timer #(
    .PERIOD_CYC(REFI_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_w),
    .tick (tick_w)
  );

  refmgr_owed_counter #(
    .MAX_OWED(MAX_OWED)
  ) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .consume(consume_w),
    .flush  (fire_enter_w),
    .owed   (owed_w),
    .urgent (urgent_w)
  );

  refmgr_sleep_seq #(
    .XSNR_CYC   (XSNR_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_fire  (fire_enter_w),
    .wake_req    (wake_req),
    .catchup_fire(catchup_fire_w),
    .state       (state_w),
    .xsnr_done   (xsnr_done_w),
    .recovered   (recovered_w)
  );

  // Entry and refresh share one encoding; CKE tells them apart.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
    end else if (fire_enter_w || fire_ref_w) begin
      cmd_q <= CMD_REFRESH;
    end else begin
      cmd_q <= CMD_DESEL;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke          = (state_w != ST_SLEEP);
  assign urgent       = urgent_w;
  assign read_allowed = run_w && recovered_w;
endmodule

// File: rtl/refmgr_checker.sv
module refmgr_checker
  import refmgr_pkg::*;
#(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          banks_idle,
  input logic          arb_req,
  input logic          urgent,
  input logic          cke,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          read_allowed,
  input mgr_state_t    state,
  input logic [OW-1:0] owed
);
  // R2
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));

  // R1
  owed_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed > $past(owed)) |-> (owed == $past(owed) + 1'b1));

  // R4
  entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(banks_idle) && !$past(urgent)));

  // R5
  entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

  // R5
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> (cs_n && !arb_req));

  // R7
  wake_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> (cke && cs_n && !arb_req));

  // R8
  catchup_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CATCHUP && state == ST_RUN) |->
      (cke && !cs_n && !ras_n && !cas_n && we_n));

  // R9
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_allowed |-> (cke && state == ST_RUN));
endmodule

bind ddr_refresh_mgr refmgr_checker #(
  .MAX_OWED(MAX_OWED)
) u_refmgr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .banks_idle  (banks_idle),
  .arb_req     (arb_req),
  .urgent      (urgent),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .read_allowed(read_allowed),
  .state       (state_w),
  .owed        (owed_w)
);

// File: tb/test_ddr_refresh_mgr.sv
module test_ddr_refresh_mgr;
  localparam int REFI  = 10;
  localparam int XSNR  = 4;
  localparam int RECOV = 12;
  localparam int CAP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic arb_gnt = 1'b0;
  logic arb_req, urgent, cke, cs_n, ras_n, cas_n, we_n, read_allowed;

  always #10 clk = ~clk;  // 50 MHz

  ddr_refresh_mgr #(
    .REFI_CYC   (REFI),
    .XSNR_CYC   (XSNR),
    .RECOVER_CYC(RECOV),
    .MAX_OWED   (CAP)
  ) i_ddr_refresh_mgr (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sleep_req(sleep_req),
    .wake_req(wake_req), .arb_gnt(arb_gnt), .arb_req(arb_req), .urgent(urgent),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .read_allowed(read_allowed)
  );

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;

  // Reference model: 0 normal, 1 asleep, 2 NOP hold, 3 catch-up wait
  int m_st = 0;
  int m_owed = 0;
  int m_run_edges = 0;
  int m_xs = 0;
  int m_rec = RECOV;
  logic [3:0] m_cmd = 4'b1111;

  function automatic bit m_urgent();
    return m_owed == CAP;
  endfunction

  function automatic bit m_sleep_ok();
    return (m_st == 0) && sleep_req && banks_idle && !m_urgent();
  endfunction

  function automatic bit m_req();
    return ((m_st == 0) && (m_owed > 0 || m_sleep_ok())) || (m_st == 3);
  endfunction

  always @(posedge clk) begin : model
    bit fire, ok, tick;
    int nxt, old;
    if (!rst_n) begin
      m_st = 0; m_owed = 0; m_run_edges = 0; m_xs = 0; m_rec = RECOV;
      m_cmd = 4'b1111;
    end else begin
      ok   = m_sleep_ok();
      fire = m_req() && arb_gnt;
      tick = ((m_run_edges + 1) % REFI) == 0;
      old  = m_st;
      m_cmd = 4'b1111;
      if (old != 1 && m_rec < RECOV) m_rec++;
      case (old)
        0: begin
          if (fire && ok) begin
            m_st = 1; m_owed = 0; m_run_edges = 0; m_cmd = 4'b0001;
          end else begin
            nxt = m_owed + (tick ? 1 : 0) - (fire ? 1 : 0);
            if (nxt > CAP) nxt = CAP;
            m_owed = nxt;
            if (fire) m_cmd = 4'b0001;
            m_run_edges++;
          end
        end
        1: if (wake_req) begin m_st = 2; m_xs = 0; m_rec = 0; end
        2: begin
          if (m_xs + 1 == XSNR) m_st = 3;
          else m_xs++;
        end
        default: if (fire) begin m_st = 0; m_run_edges = 0; m_cmd = 4'b0001; end
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 arb_req", int'(arb_req), int'(m_req()));
    chk("R2 urgent", int'(urgent), int'(m_urgent()));
    chk("R3 command", int'({cs_n, ras_n, cas_n, we_n}), int'(m_cmd));
    chk("R5 cke", int'(cke), (m_st != 1) ? 1 : 0);
    chk("R9 read_allowed", int'(read_allowed), (m_st == 0 && m_rec >= RECOV) ? 1 : 0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
    edges++;
    compare();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : driver
    int first_req, first_urg, low_cnt, e0, exp_rd;
    bit prev;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset state
    chk("R1 reset arb_req", int'(arb_req), 0);
    chk("R5 reset cke", int'(cke), 1);
    chk("R3 reset command", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk("R9 reset read_allowed", int'(read_allowed), 1);

    // R1/R2: no grants, debt piles up to the ceiling
    first_req = 0;
    first_urg = 0;
    for (int k = 1; k <= CAP * REFI + 15; k++) begin
      step();
      if (arb_req && first_req == 0) first_req = k;
      if (urgent && first_urg == 0) first_urg = k;
    end
    chk("R1 first request cycle", first_req, REFI);
    chk("R2 first urgent cycle", first_urg, CAP * REFI);

    // R4: power-down refused at the ceiling, refresh issued instead
    sleep_req = 1'b1;
    arb_gnt = 1'b1;
    step();
    chk("R4 entry refused while urgent: cke", int'(cke), 1);
    chk("R4 entry refused while urgent: command", int'({cs_n, ras_n, cas_n, we_n}), 1);
    arb_gnt = 1'b0;
    sleep_req = 1'b0;

    // R3: sweep of grant spacing against the tick cadence
    for (int p = 1; p <= 9; p++) begin
      for (int c = 0; c < REFI * 4; c++) begin
        arb_gnt = (c % p) == 0;
        step();
      end
    end

    // R10: grants with nothing owed do nothing
    arb_gnt = 1'b1;
    repeat (REFI * 3) begin
      prev = arb_req;
      step();
      if (!prev) chk("R10 grant without request", int'({cs_n, ras_n, cas_n, we_n}), 15);
    end
    arb_gnt = 1'b0;

    // Self-refresh sweep: entry delay d, catch-up delay g
    for (int g = 0; g <= 10; g++) begin
      for (int d = 0; d <= 2; d++) begin
        arb_gnt = 1'b1;
        repeat (20) if (arb_req) step();
        arb_gnt = 1'b0;
        banks_idle = 1'b0;
        sleep_req = 1'b1;
        arb_gnt = (d == 1);
        repeat (d + 1) step();
        chk("R4 busy banks hold off entry", int'(cke), 1);
        arb_gnt = 1'b0;
        banks_idle = 1'b1;
        repeat (d) step();
        arb_gnt = 1'b1;
        step();
        chk("R5 entry cke low", int'(cke), 0);
        chk("R5 entry command", int'({cs_n, ras_n, cas_n, we_n}), 1);
        sleep_req = 1'b0;
        arb_gnt = (g % 2) == 1;
        repeat (3 + d) begin
          step();
          chk("R5 silent while asleep", int'({arb_req, cke, cs_n}), 1);
        end
        arb_gnt = 1'b0;
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk("R6 cke raised on wake", int'(cke), 1);
        e0 = edges;
        low_cnt = 0;
        while (!arb_req && low_cnt < 50) begin
          low_cnt++;
          step();
        end
        chk("R7 NOP hold length", low_cnt, XSNR);
        repeat (g) step();
        arb_gnt = 1'b1;
        step();
        arb_gnt = 1'b0;
        chk("R8 catch-up refresh command", int'({cs_n, ras_n, cas_n, we_n}), 1);
        chk("R8 catch-up cke", int'(cke), 1);
        exp_rd = (RECOV > XSNR + g + 1) ? RECOV : XSNR + g + 1;
        low_cnt = 0;
        while (!read_allowed && low_cnt < 100) begin
          low_cnt++;
          step();
        end
        chk("R9 reads reopen", edges - e0, exp_rd);
      end
    end

    summary();
    $finish;
  end
endmodule